// File: doc/BRIEF.md
# Motor Lock Protection Supervisor

This block guards a three-phase motor drive against a rotor that fails to reach or hold phase lock. While the motor is commanded to run, it measures how long the lock-detect flag has stayed low without a break, counting ticks of a slow timebase. When that run of unlocked time reaches a programmable terminal count, it latches a fault that forces the low-side drive off. The fault stays set until the motor is commanded to stop or the block is reset. Regaining lock does not clear it.

Two events restart the measurement without tripping. Lock being reached is one. A change of the reference divisor select, which lowers the target speed, is the other. A disable input stands in for a grounded timing pin and removes the protection completely. A second, non-latching cause of shutdown is merged into the same output. This is an undervoltage hold driven by two comparator flags, one for the low (trip) threshold and one for the high (release) threshold, which gives hysteresis. The analog oscillator and comparators sit outside this block.

Top module: `lock_guard`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `fault` is 0, `uv_cut` is 1 and `drive_off` is 1. The unlock timer starts from zero.
- R2: The timer advances by one on each clock where `tick` is 1, but only while `stop`=0, `prot_off`=0 and `locked`=0. Any cycle with `locked`=1 clears it to zero, so unlocked runs broken by lock never trip.
- R3: If the timer value registered at an edge is at or above `trip_count`, and that edge sees `stop`=0, `locked`=0, `prot_off`=0 and no divisor change, then `fault` becomes 1 after that edge. The timer saturates at `trip_count`.
- R4: Once set, `fault` stays 1 whatever `locked`, `tick` or `prot_off` do. A clock edge with `stop`=1 clears both `fault` and the timer, so every stop-to-start transition begins clean.
- R5: With `prot_off`=1 the timer is held at zero and `fault` never sets.
- R6: An edge at which `div_sel` differs from its value at the previous edge clears the timer and cannot set `fault`.
- R7: `uv_cut` becomes 1 after an edge with `uv_trip`=1, and becomes 0 after an edge with `uv_trip`=0 and `uv_release`=1. Otherwise it holds, and it has no latching link to `stop`.
- R8: `drive_off` is 1 exactly when `fault` or `uv_cut` is 1.
- R9: A `trip_count` of 0 sets `fault` on the first qualifying edge after start, with no tick needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse from the slow timebase |
| stop | input | 1 | 1 = motor commanded to stop, 0 = run |
| locked | input | 1 | 1 = phase lock reached |
| prot_off | input | 1 | 1 = lock protection disabled |
| trip_count | input | CNT_W (16) | Unlock time in ticks that trips the fault |
| div_sel | input | SEL_W (2) | Reference divisor select, watched for changes |
| uv_trip | input | 1 | Supply below the low threshold |
| uv_release | input | 1 | Supply above the high threshold |
| fault | output | 1 | Latched lock fault |
| uv_cut | output | 1 | Undervoltage hold |
| drive_off | output | 1 | Low-side drive shutdown |

## Verification
The hardest case to reach from the ports is a divisor change that lands while the unlocked timer sits just below its terminal count. This is the one moment where a missed clear would trip the fault. The stimulus uses a small terminal count and a tick on every cycle. It walks the timer up to the edge of the trip, flips the divisor select, and repeats this several times before it finally lets the trip happen. A behavioural model follows every edge, so an off-by-one in the clear or in the saturation shows up as a mismatch on the exact cycle it occurs.

// File: rtl/lock_guard.sv
module lock_guard #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             stop,
  input  logic             locked,
  input  logic             prot_off,
  input  logic [CNT_W-1:0] trip_count,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             uv_trip,
  input  logic             uv_release,
  output logic             fault,
  output logic             uv_cut,
  output logic             drive_off
);

  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] sel_q;
  logic sel_chg, hold_clear, at_limit, trip_now;

  assign sel_chg    = div_sel != sel_q;
  assign hold_clear = stop | locked | prot_off | sel_chg;
  assign at_limit   = cnt >= trip_count;
  assign trip_now   = !hold_clear && at_limit;

  always_ff @(posedge clk) sel_q <= div_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (hold_clear)       cnt <= '0;
    else if (tick && !at_limit) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fault <= 1'b0;
    else if (stop)     fault <= 1'b0;
    else if (trip_now) fault <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          uv_cut <= 1'b1;
    else if (uv_trip)    uv_cut <= 1'b1;
    else if (uv_release) uv_cut <= 1'b0;
  end

  assign drive_off = fault | uv_cut;

endmodule

// File: rtl/lock_guard_chk.sv
module lock_guard_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop,
  input logic             locked,
  input logic             prot_off,
  input logic [SEL_W-1:0] div_sel,
  input logic             uv_trip,
  input logic             uv_release,
  input logic             fault,
  input logic             uv_cut,
  input logic             drive_off
);

  assert_fault_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !stop |=> fault);

  assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !fault);

  assert_lock_no_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !fault |=> !fault);

  assert_disabled_no_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prot_off && !fault |=> !fault);

  assert_divchg_no_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel != $past(div_sel)) && !fault |=> !fault);

  assert_uv_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uv_trip |=> uv_cut && drive_off);

  assert_uv_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uv_release && !uv_trip |=> !uv_cut);

endmodule

bind lock_guard lock_guard_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .locked(locked), .prot_off(prot_off),
  .div_sel(div_sel), .uv_trip(uv_trip), .uv_release(uv_release),
  .fault(fault), .uv_cut(uv_cut), .drive_off(drive_off)
);

// File: tb/lock_guard_tb.sv
`timescale 1ns/1ps
module lock_guard_tb;
  logic clk = 0, rst_n = 0, tick = 0, stop = 1, locked = 0, prot_off = 0;
  logic [15:0] trip_count = 16'd5;
  logic [1:0] div_sel = 0;
  logic uv_trip = 0, uv_release = 0;
  logic fault, uv_cut, drive_off;
  int errors = 0, checks = 0, tick_div = 1;
  string phase = "R1";
  bit started = 0;
  int m_cnt = 0, m_fault = 0, m_uv = 1, m_sel = 0;

  always #10 clk = ~clk;

  lock_guard u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .stop(stop), .locked(locked),
    .prot_off(prot_off), .trip_count(trip_count), .div_sel(div_sel), .uv_trip(uv_trip),
    .uv_release(uv_release), .fault(fault), .uv_cut(uv_cut), .drive_off(drive_off));

  always @(posedge clk) begin
    int nc, nf, nu; bit clr, lim;
    if (!rst_n) begin nc = 0; nf = 0; nu = 1; end
    else begin
      clr = stop || locked || prot_off || (int'(div_sel) != m_sel);
      lim = m_cnt >= int'(trip_count);
      nc = clr ? 0 : ((tick && !lim) ? m_cnt + 1 : m_cnt);
      nf = stop ? 0 : ((!clr && lim) ? 1 : m_fault);
      nu = uv_trip ? 1 : (uv_release ? 0 : m_uv);
    end
    m_cnt = nc; m_fault = nf; m_uv = nu; m_sel = int'(div_sel);
    started = 1;
    #5;
    checks++;
    if (fault !== m_fault[0] || uv_cut !== m_uv[0] || drive_off !== (m_fault[0] | m_uv[0])) begin
      errors++;
      $display("FAIL %s model: fault=%b uv_cut=%b drive_off=%b expected %0d %0d %0d",
               phase, fault, uv_cut, drive_off, m_fault, m_uv, m_fault | m_uv);
    end
  end

  task automatic expect_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      tick = 0;
      for (int i = 1; i < tick_div; i++) @(negedge clk);
      tick = 1;
    end
  end

  initial begin
    cyc(3);
    expect_bit(fault, 0, "R1 fault in reset");
    expect_bit(uv_cut, 1, "R1 uv_cut in reset");
    rst_n = 1;
    cyc(1);
    expect_bit(drive_off, 1, "R1 drive_off after reset");
    phase = "R7"; uv_release = 1; cyc(1); uv_release = 0; cyc(1);
    expect_bit(uv_cut, 0, "R7 release");
    expect_bit(drive_off, 0, "R8 drive on");
    phase = "R3"; stop = 0; cyc(3);
    expect_bit(fault, 0, "R3 before trip");
    cyc(10);
    expect_bit(fault, 1, "R3 tripped");
    expect_bit(drive_off, 1, "R8 fault forces off");
    phase = "R4"; locked = 1; prot_off = 1; cyc(6);
    expect_bit(fault, 1, "R4 fault held through lock");
    prot_off = 0; stop = 1; cyc(1); stop = 0;
    expect_bit(fault, 0, "R4 stop clears");
    phase = "R2"; cyc(20);
    expect_bit(fault, 0, "R2 locked no trip");
    for (int k = 0; k < 6; k++) begin locked = 0; cyc(4); locked = 1; cyc(1); end
    expect_bit(fault, 0, "R2 broken unlock no trip");
    phase = "R6"; locked = 0; cyc(4);
    for (int k = 0; k < 5; k++) begin div_sel = div_sel + 1; cyc(5); end
    expect_bit(fault, 0, "R6 divisor changes no trip");
    cyc(8);
    expect_bit(fault, 1, "R6 trips once divisor steady");
    phase = "R5"; stop = 1; cyc(1); prot_off = 1; stop = 0; cyc(50);
    expect_bit(fault, 0, "R5 disabled never trips");
    phase = "R9"; stop = 1; tick_div = 1000; trip_count = 0; cyc(1);
    prot_off = 0; stop = 0; cyc(2);
    expect_bit(fault, 1, "R9 zero count trips");
    phase = "R3"; stop = 1; tick_div = 4; trip_count = 16'd300; cyc(1); stop = 0;
    cyc(1150);
    expect_bit(fault, 0, "R3 slow ticks before limit");
    cyc(100);
    expect_bit(fault, 1, "R3 slow ticks tripped");
    phase = "R7"; stop = 1; cyc(1); stop = 0; locked = 1;
    uv_trip = 1; uv_release = 1; cyc(1); uv_trip = 0; uv_release = 0; cyc(5);
    expect_bit(uv_cut, 1, "R7 trip priority and hold");
    expect_bit(drive_off, 1, "R8 uv forces off");
    uv_release = 1; cyc(1); uv_release = 0; cyc(1);
    expect_bit(drive_off, 0, "R8 all clear");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule